// File: doc/BRIEF.md
# Watchdog Timer with Register Interface

The block is a watchdog timer peripheral that sits on a simple 32-bit register slave port. Software picks one of sixteen power-of-two timeout periods by a 4-bit index, chooses a response mode and a reset pulse width, and then sets the enable bit. From that point a down-counter runs on the peripheral clock. Software keeps the system alive by writing a fixed restart key. Any other value written to the restart location is ignored.

When the counter runs out, the block reacts in one of two ways, selected by the response mode. In direct mode it requests a system reset at once. In interrupt mode the first expiry raises an interrupt and reloads the counter. If that interrupt is still pending at the next expiry, the block requests a reset. The reset request is a pulse whose length is set by a 3-bit code. Once set, the enable bit stays set until a hardware reset. The parameter `BASE_SHIFT` scales all sixteen periods together. Its default gives start counts from 0xFFFF up to 0x7FFFFFFF.

Only the low byte of write data is decoded by any register, so the write data port is 8 bits wide. Read data is combinational from the address during a read cycle. A read side effect, where one applies, takes place on the clock edge that ends the read cycle.

Top module: `wdt_core`

## Requirements
- R1: After reset, every register reads as zero except the timeout index at offset 0x04, which reads 15. The interrupt and reset request outputs are low.
- R2: The control register at offset 0x00 holds the enable in bit 0, the response mode in bit 1 (0 = direct reset, 1 = interrupt first) and the pulse code in bits 4:2. It reads back in the same positions.
- R3: Once the enable bit is set, a write with bit 0 clear leaves it set. Only the hardware reset clears it.
- R4: Timeout index i, held in bits 3:0 of offset 0x04, loads a start count of 2^(BASE_SHIFT+i) − 1 when the timer is enabled. The counter reads at offset 0x08 and decrements by one each clock. Expiry takes effect 2^(BASE_SHIFT+i) cycles after the enabling write.
- R5: A write to offset 0x0C whose data equals 0x76 reloads the counter from the selected period and clears a pending interrupt.
- R6: A write to offset 0x0C with any other data changes neither the counter nor the interrupt status.
- R7: In response mode 0, an expiry raises the system reset request on the next cycle.
- R8: In response mode 1, a first expiry sets the interrupt status and output without requesting a reset, and it reloads the counter. Bit 0 of offset 0x10 shows the status.
- R9: In response mode 1, an expiry that occurs while the interrupt is still pending requests a system reset.
- R10: A read of offset 0x14 clears the interrupt status and output.
- R11: The reset request stays high for 2^(code+1) consecutive cycles, where code is control bits 4:2.
- R12: While the timer is disabled, the counter holds zero and no expiry occurs, whatever the timeout index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data (low byte; no register decodes wider) |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Interrupt, high while status is pending |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
A write takes effect on the clock edge that ends its bus cycle. A counter read in the following cycle returns the start count, and each later cycle returns one less. An expiry shows at the outputs exactly 2^(BASE_SHIFT+i) edges after the enabling edge. A second expiry follows after twice that many edges. The reset pulse lasts 2^(code+1) edges.

The bench drives inputs on falling edges and samples on falling edges or just after them. It keeps a free-running edge count, so it can compare the cycle in which a rise appears with the count expected from the index. It uses a small `BASE_SHIFT` so that it can sweep the indices, the pulse codes and both response modes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int IDX_W  = 4;
    localparam int CODE_W = 3;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_TOUT = 8'h04;
    localparam logic [7:0] OFS_CNT  = 8'h08;
    localparam logic [7:0] OFS_KICK = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_ACK  = 8'h14;

    localparam logic [7:0] KICK_KEY = 8'h76;

    typedef enum logic {
        RESP_RESET = 1'b0,
        RESP_IRQ   = 1'b1
    } resp_e;
endpackage

// File: rtl/wdt_downcnt.sv
module wdt_downcnt #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && !load && (cnt_q == '0);
        cnt_d  = cnt_q;
        if (load || expire)
            cnt_d = load_val;
        else if (run)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [CODE_W-1:0] code,
    output logic              active
);
    localparam int LEN_W = 1 << CODE_W;

    typedef struct packed {
        logic             act;
        logic [LEN_W-1:0] left;
    } pstate_t;

    pstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.act  = 1'b1;
            st_d.left = {LEN_W{1'b1}} >> (CODE_W'(LEN_W - 1) - code);
        end else if (st_q.act) begin
            if (st_q.left == '0) st_d.act = 1'b0;
            else                 st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && st_q.left != '0 && !fire) |=> st_q.act); // R11
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act && st_q.left == '0 && !fire) |=> !st_q.act); // R11
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int BASE_SHIFT = 16,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sys_rst_req
);
    localparam int NUM_IDX = 1 << IDX_W;
    localparam int CNT_W   = BASE_SHIFT + NUM_IDX - 1;

    typedef struct packed {
        logic              en;
        resp_e             mode;
        logic [CODE_W-1:0] code;
        logic [IDX_W-1:0]  idx;
        logic              irq;
    } regs_t;

    localparam regs_t REGS_RST = '{en: 1'b0, mode: RESP_RESET, code: '0,
                                   idx: IDX_W'(NUM_IDX - 1), irq: 1'b0};

    regs_t r_d, r_q;

    logic             wr, rd;
    logic             hit_ctrl, hit_tout, hit_cnt, hit_kick, hit_stat, hit_ack;
    logic             kick_ok, en_rise, cnt_load, expire, fire, irq_set;
    logic [CNT_W-1:0] period, cnt;

    always_comb begin
        wr       = bus_sel && bus_write;
        rd       = bus_sel && !bus_write;
        hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_tout = (bus_addr == ADDR_W'(OFS_TOUT));
        hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
        hit_kick = (bus_addr == ADDR_W'(OFS_KICK));
        hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
        hit_ack  = (bus_addr == ADDR_W'(OFS_ACK));

        period   = {CNT_W{1'b1}} >> (IDX_W'(NUM_IDX - 1) - r_q.idx);
        kick_ok  = wr && hit_kick && (bus_wdata == KICK_KEY) && r_q.en;
        en_rise  = wr && hit_ctrl && bus_wdata[0] && !r_q.en;
        cnt_load = kick_ok || en_rise;

        fire     = expire && ((r_q.mode == RESP_RESET) || r_q.irq);
        irq_set  = expire && (r_q.mode == RESP_IRQ) && !r_q.irq;

        r_d = r_q;
        if (wr && hit_ctrl) begin
            r_d.en   = r_q.en | bus_wdata[0];
            r_d.mode = resp_e'(bus_wdata[1]);
            r_d.code = bus_wdata[CODE_W+1:2];
        end
        if (wr && hit_tout)
            r_d.idx = bus_wdata[IDX_W-1:0];
        if ((rd && hit_ack) || kick_ok)
            r_d.irq = 1'b0;
        if (irq_set)
            r_d.irq = 1'b1;

        bus_rdata = '0;
        if (rd) begin
            if (hit_ctrl) bus_rdata = 32'({r_q.code, r_q.mode, r_q.en});
            if (hit_tout) bus_rdata = 32'(r_q.idx);
            if (hit_cnt)  bus_rdata = 32'(cnt);
            if (hit_stat) bus_rdata = 32'(r_q.irq);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    wdt_downcnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (r_q.en),
        .load     (cnt_load),
        .load_val (period),
        .cnt      (cnt),
        .expire   (expire)
    );

    wdt_pulse #(.CODE_W(CODE_W)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .code   (r_q.code),
        .active (sys_rst_req)
    );

    assign irq = r_q.irq;

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.en |=> r_q.en); // R3
    AST_DIRECT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && r_q.mode == RESP_RESET) |=> sys_rst_req); // R7
    AST_FIRST_EXPIRY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && r_q.mode == RESP_IRQ && !r_q.irq) |=> irq); // R8
    AST_SECOND_EXPIRY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && r_q.irq) |=> sys_rst_req); // R9
    AST_BAD_KEY_NO_IRQ_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_kick && bus_wdata != KICK_KEY && !expire) |=> (irq == $past(irq))); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_ack && !expire) |=> !irq); // R10
    AST_IDLE_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |-> !expire); // R12
endmodule

// File: tb/sim_wdt_core.sv
`timescale 1ns/1ps
module sim_wdt_core;
    localparam int BS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, sys_rst_req;

    int vec = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_core #(.BASE_SHIFT(BS), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_rise(input bit use_irq, output int n);
        n = -1;
        for (int k = 0; k < 5000; k++) begin
            if (use_irq ? irq : sys_rst_req) begin
                n = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #750000;
        bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n0, n1, w;

        // R1 reset state
        do_reset();
        rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
        rd(8'h04, d); check(d == 15, "R1 tout", d, 15);
        rd(8'h08, d); check(d == 0, "R1 cnt", d, 0);
        rd(8'h10, d); check(d == 0, "R1 stat", d, 0);
        check(irq == 0, "R1 irq", irq, 0);
        check(sys_rst_req == 0, "R1 rst", sys_rst_req, 0);

        // R12 disabled timer does not run
        wr(8'h04, 8'h00);
        repeat (20) @(negedge clk);
        rd(8'h08, d); check(d == 0, "R12 cnt idle", d, 0);
        check(sys_rst_req == 0 && irq == 0, "R12 no expiry", sys_rst_req, 0);

        // R2 / R3 layout and sticky enable
        wr(8'h04, 8'h0F);
        wr(8'h00, 8'h1D);
        rd(8'h00, d); check(d == 32'h1D, "R2 readback", d, 32'h1D);
        wr(8'h00, 8'h02);
        rd(8'h00, d); check(d == 32'h03, "R3 sticky", d, 32'h03);
        wr(8'h00, 8'h00);
        rd(8'h00, d); check(d[0] == 1'b1, "R3 sticky zero write", d[0], 1);

        // R4 / R7 index sweep, mode 0
        for (int i = 0; i < 4; i++) begin
            longint p;
            p = (longint'(1) << (BS + i)) - 1;
            do_reset();
            wr(8'h04, 8'(i));
            wr(8'h00, 8'h01);
            n0 = cyc;
            for (int k = 0; k < 3; k++) begin
                rd(8'h08, d);
                check(d == p - k, "R4 count", d, p - k);
            end
            wait_rise(1'b0, n1);
            check(n1 - n0 == p + 1, "R7 expiry time", n1 - n0, p + 1);
            check(irq == 0, "R7 no irq", irq, 0);
        end

        // R11 pulse width sweep
        for (int c = 0; c < 8; c++) begin
            do_reset();
            wr(8'h04, 8'h07);
            wr(8'h00, 8'((c << 2) | 1));
            n0 = cyc;
            wait_rise(1'b0, n1);
            check(n1 - n0 == 512, "R4 idx7 expiry", n1 - n0, 512);
            w = 0;
            while (sys_rst_req && w < 1000) begin
                w++;
                @(negedge clk);
            end
            check(w == (1 << (c + 1)), "R11 pulse width", w, 1 << (c + 1));
        end

        // R8 / R9 interrupt first, then reset
        do_reset();
        wr(8'h04, 8'h01);
        wr(8'h00, 8'h03);
        n0 = cyc;
        wait_rise(1'b1, n1);
        check(n1 - n0 == 8, "R8 irq time", n1 - n0, 8);
        check(sys_rst_req == 0, "R8 no reset", sys_rst_req, 0);
        n0 = n1;
        rd(8'h10, d); check(d == 1, "R8 status", d, 1);
        rd(8'h08, d); check(d == 6, "R8 reload", d, 6);
        wait_rise(1'b0, n1);
        check(n1 - n0 == 8, "R9 reset time", n1 - n0, 8);

        // R10 read of ack clears, next expiry only re-raises irq
        do_reset();
        wr(8'h04, 8'h03);
        wr(8'h00, 8'h03);
        n0 = cyc;
        wait_rise(1'b1, n1);
        check(n1 - n0 == 32, "R8 irq idx3", n1 - n0, 32);
        rd(8'h14, d);
        check(irq == 0, "R10 irq cleared", irq, 0);
        rd(8'h10, d); check(d == 0, "R10 status cleared", d, 0);
        wait_rise(1'b1, n1);
        check(n1 - n0 == 64, "R10 re-raise time", n1 - n0, 64);
        check(sys_rst_req == 0, "R10 no reset", sys_rst_req, 0);

        // R5 / R6 restart key
        do_reset();
        wr(8'h04, 8'h02);
        wr(8'h00, 8'h01);
        rd(8'h08, d); check(d == 15, "R5 start", d, 15);
        wr(8'h0C, 8'h75);
        rd(8'h08, d); check(d == 13, "R6 bad key ignored", d, 13);
        wr(8'h0C, 8'h76);
        rd(8'h08, d); check(d == 15, "R5 reload", d, 15);

        do_reset();
        wr(8'h04, 8'h00);
        wr(8'h00, 8'h03);
        wait_rise(1'b1, n1);
        wr(8'h0C, 8'h67);
        check(irq == 1, "R6 bad key keeps irq", irq, 1);
        wr(8'h0C, 8'h76);
        check(irq == 0, "R5 key clears irq", irq, 0);
        rd(8'h08, d); check(d == 3, "R5 reload idx0", d, 3);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule